// File: doc/BRIEF.md
# LIN Channel Pair Loopback Router

This block sits between a bank of LIN controller channels and the device pad signals. In its normal state every channel is wired straight through: its transmit and receive inputs come from its own pad inputs, and its transmit output drives its own pad output. A single 32-bit control register, written and read over a plain register bus, can put the block into a test state. In that state one chosen channel is paired with the highest-numbered channel, and the two transmit outputs are merged as a wired-AND.

The register picks one of two test flavours. With loopback through the pad, both paired channels listen to the transmit-input pad signal of the chosen channel, so the merged traffic can be seen and driven from outside. With full isolation, both paired channels listen only to the merged AND value itself, which forms a closed internal loop that leaves any attached bus untouched at the input side. All routing is combinational from the stored register value.

Top module: `lin_loop_router`

## Requirements
- R1: After reset the control register reads as 0x00000000, so every channel has normal routing.
- R2: A write stores the selected index in bits 4:0, the isolation-mode bit in bit 16 and the test-enable bit in bit 31. The value is visible on the read data and in the routing in the clock cycle after the write strobe.
- R3: Bits 5 to 15 and 17 to 30 ignore written ones and always read as zero.
- R4: With test-enable at 0, every channel's transmit input, receive input and pad output equal its own pad transmit input, its own pad receive input and its own transmit output.
- R5: With test-enable at 1 and a valid index (0 to CH_NR-2), the pad outputs of the chosen channel and of channel CH_NR-1 both carry the AND of those two channels' transmit outputs.
- R6: With test active, a valid index and mode bit 0, the transmit and receive inputs of both paired channels all carry the pad transmit input of the chosen channel. The pad receive inputs of the pair have no effect.
- R7: With test active, a valid index and mode bit 1, the transmit and receive inputs of both paired channels all carry the AND of the two channels' transmit outputs. The pad inputs of the pair have no effect.
- R8: With test-enable at 1 and an index of CH_NR-1 or more, all channels keep normal routing.
- R9: Channels other than the chosen one and CH_NR-1 keep normal routing whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register value |
| chanTxOut | input | CH_NR | Transmit output of each channel |
| chanTxIn | output | CH_NR | Transmit-sense input to each channel |
| chanRxIn | output | CH_NR | Receive input to each channel |
| padTxIn | input | CH_NR | Transmit-sense signal from each pad |
| padRxIn | input | CH_NR | Receive signal from each pad |
| padTxOut | output | CH_NR | Transmit signal toward each pad |

## Verification
The routing is driven with complementary pad and channel patterns (pad transmit inputs opposite to pad receive inputs, channel outputs alternating), so a swapped or crossed connection gives a different bit than the right one. The paired transmit outputs are set to all four combinations of 0 and 1, which separates an AND from an OR or a pass-through. Both modes run with the pad transmit input of the chosen channel opposite to the AND value, so the two loop sources cannot be confused. Indices at CH_NR-2, CH_NR-1 and 31 show where the valid range ends.

// File: rtl/lin_loop_pkg.sv
package lin_loop_pkg;
  localparam int SEL_W   = 5;
  localparam int ISO_BIT = 16;
  localparam int EN_BIT  = 31;
  localparam logic [31:0] USED_MASK = 32'h8001_001F;

  // strobes from the control side to the routing datapath
  typedef struct packed {
    logic             pairOn;   // test active with a valid index
    logic             fullIso;  // 1: internal loop, 0: loop via pad
    logic [SEL_W-1:0] selIdx;   // channel paired with the last one
  } route_ctl_t;
endpackage

// File: rtl/lin_loop_ctrl.sv
module lin_loop_ctrl
  import lin_loop_pkg::*;
#(
  parameter int CH_NR = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output route_ctl_t  routeCtl
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(CH_NR - 1);

  logic             testEn;
  logic             isoMode;
  logic [SEL_W-1:0] selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testEn  <= 1'b0;
      isoMode <= 1'b0;
      selReg  <= '0;
    end else if (wrEn) begin
      testEn  <= wrData[EN_BIT];
      isoMode <= wrData[ISO_BIT];
      selReg  <= wrData[SEL_W-1:0];
    end
  end

  always_comb begin
    rdData                = '0;
    rdData[EN_BIT]        = testEn;
    rdData[ISO_BIT]       = isoMode;
    rdData[SEL_W-1:0]     = selReg;
    routeCtl.pairOn       = testEn && (selReg < LAST_IDX);
    routeCtl.fullIso      = isoMode;
    routeCtl.selIdx       = selReg;
  end
endmodule

// File: rtl/lin_loop_route.sv
module lin_loop_route
  import lin_loop_pkg::*;
#(
  parameter int CH_NR = 8
) (
  input  route_ctl_t       routeCtl,
  input  logic [CH_NR-1:0] chanTxOut,
  output logic [CH_NR-1:0] chanTxIn,
  output logic [CH_NR-1:0] chanRxIn,
  input  logic [CH_NR-1:0] padTxIn,
  input  logic [CH_NR-1:0] padRxIn,
  output logic [CH_NR-1:0] padTxOut
);
  localparam int LAST = CH_NR - 1;

  logic [CH_NR-1:0] selHot;
  logic             selTxOut;
  logic             selPadTx;
  logic             wiredAnd;
  logic             loopSrc;

  for (genvar i = 0; i < CH_NR; i++) begin : g_hot
    assign selHot[i] = (routeCtl.selIdx == SEL_W'(i));
  end

  assign selTxOut = |(chanTxOut & selHot);
  assign selPadTx = |(padTxIn & selHot);
  assign wiredAnd = selTxOut & chanTxOut[LAST];
  assign loopSrc  = routeCtl.fullIso ? wiredAnd : selPadTx;

  for (genvar i = 0; i < CH_NR; i++) begin : g_chan
    logic inPair;
    if (i == LAST) begin : g_last
      assign inPair = routeCtl.pairOn;
    end else begin : g_other
      assign inPair = routeCtl.pairOn && selHot[i];
    end
    assign chanTxIn[i] = inPair ? loopSrc  : padTxIn[i];
    assign chanRxIn[i] = inPair ? loopSrc  : padRxIn[i];
    assign padTxOut[i] = inPair ? wiredAnd : chanTxOut[i];
  end
endmodule

// File: rtl/lin_loop_router.sv
module lin_loop_router
  import lin_loop_pkg::*;
#(
  parameter int CH_NR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic [CH_NR-1:0] chanTxOut,
  output logic [CH_NR-1:0] chanTxIn,
  output logic [CH_NR-1:0] chanRxIn,
  input  logic [CH_NR-1:0] padTxIn,
  input  logic [CH_NR-1:0] padRxIn,
  output logic [CH_NR-1:0] padTxOut
);
  route_ctl_t routeCtl;

  lin_loop_ctrl #(.CH_NR(CH_NR)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .routeCtl(routeCtl)
  );

  lin_loop_route #(.CH_NR(CH_NR)) u_route (
    .routeCtl(routeCtl), .chanTxOut(chanTxOut), .chanTxIn(chanTxIn),
    .chanRxIn(chanRxIn), .padTxIn(padTxIn), .padRxIn(padRxIn),
    .padTxOut(padTxOut)
  );
endmodule

// File: rtl/lin_loop_router_chk.sv
module lin_loop_router_chk
  import lin_loop_pkg::*;
#(
  parameter int CH_NR = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic [CH_NR-1:0] chanTxOut,
  input logic [CH_NR-1:0] chanTxIn,
  input logic [CH_NR-1:0] chanRxIn,
  input logic [CH_NR-1:0] padTxIn,
  input logic [CH_NR-1:0] padRxIn,
  input logic [CH_NR-1:0] padTxOut
);
  localparam int LAST = CH_NR - 1;

  logic [CH_NR-1:0] shPadTx;
  logic [CH_NR-1:0] shTxOut;
  logic [CH_NR-1:0] shPadOut;
  logic             validPair;
  assign shPadTx   = padTxIn   >> rdData[4:0];
  assign shTxOut   = chanTxOut >> rdData[4:0];
  assign shPadOut  = padTxOut  >> rdData[4:0];
  assign validPair = rdData[31] && (rdData[4:0] < 5'(LAST));

  // R1
  always @(posedge clk) if (!rstN) reset_zero_chk: assert (rdData == 32'h0);

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & USED_MASK));

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~USED_MASK) == 32'h0);

  // R4
  normal_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[31] |-> (chanTxIn == padTxIn && chanRxIn == padRxIn && padTxOut == chanTxOut));

  // R5
  wired_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    validPair |-> (padTxOut[LAST] == (shTxOut[0] & chanTxOut[LAST]) && shPadOut[0] == padTxOut[LAST]));

  // R6
  pad_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validPair && !rdData[16]) |-> (chanRxIn[LAST] == shPadTx[0] && chanTxIn[LAST] == shPadTx[0]));

  // R7
  int_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validPair && rdData[16]) |-> (chanRxIn[LAST] == padTxOut[LAST] && chanTxIn[LAST] == padTxOut[LAST]));

  // R8
  bad_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31] && !validPair) |-> (padTxOut == chanTxOut && chanRxIn == padRxIn));
endmodule

bind lin_loop_router lin_loop_router_chk #(.CH_NR(CH_NR)) u_chk (.*);

// File: tb/lin_loop_router_test.sv
`timescale 1ns/1ps
module lin_loop_router_test;
  localparam int CH = 8;
  localparam int LAST = CH - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [CH-1:0] chanTxOut = '0, chanTxIn, chanRxIn;
  logic [CH-1:0] padTxIn = '0, padRxIn = '0, padTxOut;
  logic [31:0]   ctlShadow = '0;
  int total = 0;
  int bad = 0;

  lin_loop_router #(.CH_NR(CH)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: run hung");
    report();
  end

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'hFFFF_FFFF;
    ctlShadow = d & 32'h8001_001F;
  endtask

  // reference model from the requirements
  task automatic checkRoute(string tag);
    logic en, iso, pair, selTx, selPad, andV, src;
    int s;
    logic [CH-1:0] eTx, eRx, eOut;
    en = ctlShadow[31]; iso = ctlShadow[16]; s = int'(ctlShadow[4:0]);
    pair = en && (s < LAST);
    selTx = 1'b0; selPad = 1'b0;
    for (int i = 0; i < CH; i++) if (i == s) begin selTx = chanTxOut[i]; selPad = padTxIn[i]; end
    andV = selTx & chanTxOut[LAST];
    src = iso ? andV : selPad;
    for (int i = 0; i < CH; i++) begin
      if (pair && (i == s || i == LAST)) begin
        eTx[i] = src; eRx[i] = src; eOut[i] = andV;
      end else begin
        eTx[i] = padTxIn[i]; eRx[i] = padRxIn[i]; eOut[i] = chanTxOut[i];
      end
    end
    #1;
    checkVal({tag, " txIn"},  32'(chanTxIn), 32'(eTx));
    checkVal({tag, " rxIn"},  32'(chanRxIn), 32'(eRx));
    checkVal({tag, " padOut"}, 32'(padTxOut), 32'(eOut));
  endtask

  task automatic drive(logic [CH-1:0] ct, logic [CH-1:0] pt, logic [CH-1:0] pr);
    @(negedge clk);
    chanTxOut = ct; padTxIn = pt; padRxIn = pr;
  endtask

  task automatic testReset();
    #1 checkVal("R1 in reset", rdData, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after reset", rdData, 32'h0);
    drive(8'hA5, 8'h3C, 8'hC3);
    checkRoute("R1 routing");
  endtask

  task automatic testRegFields();
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h8001_0003;
    #1 checkVal("R2 before edge", rdData, 32'h0);
    @(posedge clk); #1;
    checkVal("R2 fields", rdData, 32'h8001_0003);
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    ctlShadow = 32'h8001_0003;
    @(negedge clk);
    checkVal("R2 held without strobe", rdData, 32'h8001_0003);
    writeReg(32'h7FFE_FFE0);
    checkVal("R3 reserved ones", rdData, 32'h0);
    writeReg(32'hFFFF_FFFF);
    checkVal("R3 all ones", rdData, 32'h8001_001F);
  endtask

  task automatic testNormal();
    writeReg(32'h0001_0002);
    drive(8'h55, 8'hF0, 8'h0F); checkRoute("R4 pattern a");
    drive(8'hAA, 8'h0F, 8'hF0); checkRoute("R4 pattern b");
  endtask

  task automatic testPadLoop();
    writeReg(32'h8000_0002);
    for (int k = 0; k < 4; k++) begin
      logic [CH-1:0] ct;
      ct = 8'h55;
      ct[2] = k[0]; ct[LAST] = k[1];
      drive(ct, 8'hFB, 8'h04); checkRoute("R5 R6 pad loop");
    end
    drive(8'hFF, 8'h04, 8'hFB); checkRoute("R6 pad tx high");
    checkVal("R9 ch0 rx", 32'(chanRxIn[0]), 32'(padRxIn[0]));
  endtask

  task automatic testIntLoop();
    writeReg(32'h8001_0000);
    for (int k = 0; k < 4; k++) begin
      logic [CH-1:0] ct;
      ct = 8'h2A;
      ct[0] = k[0]; ct[LAST] = k[1];
      drive(ct, 8'hFF, 8'hFF); checkRoute("R7 internal loop");
    end
    writeReg(32'h8001_0000 | 32'(LAST - 1));
    drive(8'hC0, 8'h00, 8'h00); checkRoute("R7 top valid index");
    checkVal("R9 ch1 padOut", 32'(padTxOut[1]), 32'(chanTxOut[1]));
  endtask

  task automatic testBadIndex();
    writeReg(32'h8001_0000 | 32'(LAST));
    drive(8'h7F, 8'h96, 8'h69); checkRoute("R8 index last");
    writeReg(32'h8000_001F);
    drive(8'h80, 8'h69, 8'h96); checkRoute("R8 index 31");
  endtask

  initial begin
    testReset();
    testRegFields();
    testNormal();
    testPadLoop();
    testIntLoop();
    testBadIndex();
    report();
  end
endmodule